// File: doc/BRIEF.md
# Transaction ID remapper with fixed and dynamic slots

This block sits on the request path from a system interconnect to a cache-coherent slave port. Upstream masters use wide transaction IDs. The coherent port accepts only a 3-bit ID. The block translates each write-address and read-address request into one of the output slots. On the way back, it restores the original ID on write responses and read responses. It also moves each request address into a fixed coherent window and rewrites the 5-bit user sideband field. It passes handshakes through combinationally and holds no data.

Output IDs 0 and 1 belong to other agents, so slots 2 to 7 are the only ones the block issues. A register port sets the mode of each slot. A fixed slot always serves one programmed input ID. A dynamic slot is handed out on demand to any input ID that has no slot yet. A dynamic slot stays bound to its input ID while that ID has work in flight. Later requests with the same ID reuse the binding, which keeps them in order. When the slot's last outstanding transaction completes, the slot returns to the free pool.

Top module: `idmap_remap`

## Requirements
- R1: Output IDs below FIRST_SLOT (0 and 1 by default) are never presented on `m_aw_id` or `m_ar_id`. When no usable slot exists, the request stalls instead.
- R2: The top slot (7) is dynamic only. A register write that asks for fixed mode on it is ignored: the slot stays in the dynamic pool and `cfg_err` keeps its value. Writes to slots 0 and 1 are ignored the same way.
- R3: A request whose ID equals the binding of a fixed slot is issued in the same cycle on that slot's output ID.
- R4: A request whose ID has neither a fixed slot nor a live dynamic binding gets the lowest-numbered free dynamic slot. The binding is recorded when the request is accepted.
- R5: While a dynamic slot has outstanding transactions, requests with the same input ID, on either channel, reuse that slot.
- R6: After reset, slot 2 is fixed to DEBUG_ID (12'h0A5 by default), every other slot is dynamic and idle, no request valid is driven, and `cfg_err` is 0.
- R7: The forwarded user field equals (input user AND 5'b11110) OR 5'b00001 with the default USER_KEEP/USER_SET.
- R8: The forwarded address keeps the low 30 bits of the request and replaces the top 2 bits with WIN_TOP (2'b10 by default).
- R9: A slot's outstanding count rises by one per accepted request. It falls by one per accepted write response and by one per accepted read response beat with `last` set. A read beat without `last` leaves it unchanged. At zero, a dynamic slot is free and may be bound to a different input ID.
- R10: A slot holds at most MAX_OUT (6) outstanding transactions. A request that would exceed this limit, or that finds no slot, sees both its ready and the downstream valid held low.
- R11: When both channels need a new dynamic slot in the same cycle, the write request takes the lowest free slot and the read request the next one.
- R12: A register write to slot 2..6, or a dynamic-mode write to slot 7, changes the slot and clears `cfg_err` only when the slot has no outstanding transactions. Otherwise the slot is left unchanged and `cfg_err` is set.
- R13: A response arriving on output ID k leaves with the input ID currently bound to slot k. Its valid and ready pass straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_slot | input | 3 | Slot addressed by the write |
| cfg_fixed | input | 1 | Requested mode: 1 fixed, 0 dynamic |
| cfg_id | input | IN_ID_W | Input ID bound by a fixed-mode write |
| cfg_err | output | 1 | Last non-ignored write was rejected |
| s_aw_valid | input | 1 | Upstream write request valid |
| s_aw_ready | output | 1 | Upstream write request ready |
| s_aw_id | input | IN_ID_W | Upstream write ID |
| s_aw_addr | input | ADDR_W | Upstream write address |
| s_aw_user | input | USER_W | Upstream write user field |
| m_aw_valid | output | 1 | Downstream write request valid |
| m_aw_ready | input | 1 | Downstream write request ready |
| m_aw_id | output | 3 | Remapped write ID |
| m_aw_addr | output | ADDR_W | Relocated write address |
| m_aw_user | output | USER_W | Rewritten write user field |
| s_ar_valid | input | 1 | Upstream read request valid |
| s_ar_ready | output | 1 | Upstream read request ready |
| s_ar_id | input | IN_ID_W | Upstream read ID |
| s_ar_addr | input | ADDR_W | Upstream read address |
| s_ar_user | input | USER_W | Upstream read user field |
| m_ar_valid | output | 1 | Downstream read request valid |
| m_ar_ready | input | 1 | Downstream read request ready |
| m_ar_id | output | 3 | Remapped read ID |
| m_ar_addr | output | ADDR_W | Relocated read address |
| m_ar_user | output | USER_W | Rewritten read user field |
| m_b_valid | input | 1 | Write response valid from slave |
| m_b_ready | output | 1 | Write response ready to slave |
| m_b_id | input | 3 | Write response output ID |
| s_b_valid | output | 1 | Write response valid upstream |
| s_b_ready | input | 1 | Write response ready upstream |
| s_b_id | output | IN_ID_W | Restored write response ID |
| m_r_valid | input | 1 | Read beat valid from slave |
| m_r_ready | output | 1 | Read beat ready to slave |
| m_r_id | input | 3 | Read beat output ID |
| m_r_last | input | 1 | Final beat of a read |
| s_r_valid | output | 1 | Read beat valid upstream |
| s_r_ready | input | 1 | Read beat ready upstream |
| s_r_id | output | IN_ID_W | Restored read beat ID |
| s_r_last | output | 1 | Final beat flag upstream |

## Verification
The assertions assume the slave is well behaved. It only returns a write response or a final read beat on an output ID that has work outstanding, so a count never drops below zero. They also assume upstream IDs are stable while a request waits. The stimulus keeps to this: every response the bench injects uses a slot it earlier saw issued and not yet retired. Each request is held for exactly one cycle, with downstream ready high, so an issued request is always accepted.

// File: rtl/idmap_pkg.sv
package idmap_pkg;
   localparam int unsigned OID_W = 3;
   localparam int unsigned NSLOT = 1 << OID_W;
   typedef logic [OID_W-1:0] oid_t;
   typedef enum logic {SLOT_DYN = 1'b0, SLOT_FIX = 1'b1} slot_mode_e;
endpackage

// File: rtl/idmap_lookup.sv
module idmap_lookup
   import idmap_pkg::*;
#(
   parameter int unsigned IN_ID_W = 12,
   parameter int unsigned FIRST   = 2,
   parameter int unsigned MAX_OUT = 6,
   parameter int unsigned CNT_W   = 3
) (
   input  logic [IN_ID_W-1:0]              req_id,
   input  logic [NSLOT-1:0]                fixed,
   input  logic [NSLOT-1:0][IN_ID_W-1:0]   binding,
   input  logic [NSLOT-1:0][CNT_W-1:0]     cnt,
   input  logic [NSLOT-1:0]                block,
   output logic                            found,
   output logic                            alloc,
   output logic                            full,
   output oid_t                            slot
);
   logic fix_any, dyn_any, free_any;
   oid_t fix_s, dyn_s, free_s;

   wire unused_low = ^{fixed[FIRST-1:0], binding[FIRST-1:0], block[FIRST-1:0]};

   // scan downward so the lowest matching slot is the one kept
   always_comb begin
      fix_any  = 1'b0;
      dyn_any  = 1'b0;
      free_any = 1'b0;
      fix_s    = '0;
      dyn_s    = '0;
      free_s   = '0;
      for (int i = NSLOT - 1; i >= int'(FIRST); i--) begin
         if (fixed[i] && binding[i] == req_id) begin
            fix_any = 1'b1;
            fix_s   = OID_W'(i);
         end
         if (!fixed[i] && cnt[i] != '0 && binding[i] == req_id) begin
            dyn_any = 1'b1;
            dyn_s   = OID_W'(i);
         end
         if (!fixed[i] && cnt[i] == '0 && !block[i]) begin
            free_any = 1'b1;
            free_s   = OID_W'(i);
         end
      end
   end

   always_comb begin
      found = fix_any | dyn_any | free_any;
      alloc = !fix_any && !dyn_any && free_any;
      if (fix_any)      slot = fix_s;
      else if (dyn_any) slot = dyn_s;
      else              slot = free_s;
      full = (cnt[slot] == CNT_W'(MAX_OUT));
   end
endmodule

// File: rtl/idmap_slot_table.sv
module idmap_slot_table
   import idmap_pkg::*;
#(
   parameter int unsigned IN_ID_W  = 12,
   parameter int unsigned FIRST    = 2,
   parameter int unsigned FIX_LAST = 6,
   parameter int unsigned DBG_SLOT = 2,
   parameter logic [IN_ID_W-1:0] DEBUG_ID = 12'h0A5,
   parameter int unsigned CNT_W    = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  oid_t                           cfg_slot,
   input  logic                           cfg_fixed,
   input  logic [IN_ID_W-1:0]             cfg_id,
   output logic                           cfg_err,
   input  logic [NSLOT-1:0]               inc_w,
   input  logic [NSLOT-1:0]               inc_r,
   input  logic [NSLOT-1:0]               dec_w,
   input  logic [NSLOT-1:0]               dec_r,
   input  logic [NSLOT-1:0]               bind_w,
   input  logic [IN_ID_W-1:0]             bind_w_id,
   input  logic [NSLOT-1:0]               bind_r,
   input  logic [IN_ID_W-1:0]             bind_r_id,
   output logic [NSLOT-1:0]               fixed_o,
   output logic [NSLOT-1:0][IN_ID_W-1:0]  bind_o,
   output logic [NSLOT-1:0][CNT_W-1:0]    cnt_o
);
   logic [NSLOT-1:0] acc_v, rej_v;

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      if (g < FIRST) begin : g_rsvd
         assign fixed_o[g] = 1'b0;
         assign bind_o[g]  = '0;
         assign cnt_o[g]   = '0;
         assign acc_v[g]   = 1'b0;
         assign rej_v[g]   = 1'b0;
         wire unused_rsvd = ^{inc_w[g], inc_r[g], dec_w[g], dec_r[g], bind_w[g], bind_r[g]};
      end else begin : g_live
         logic                mode_q;
         logic [IN_ID_W-1:0]  id_q;
         logic [CNT_W-1:0]    cnt_q;
         logic                hit, ignore, busy;

         assign hit    = cfg_we && cfg_slot == OID_W'(g);
         assign ignore = (g > FIX_LAST) && cfg_fixed;
         assign busy   = cnt_q != '0 || inc_w[g] || inc_r[g];
         assign acc_v[g] = hit && !ignore && !busy;
         assign rej_v[g] = hit && !ignore && busy;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mode_q <= (g == DBG_SLOT) ? SLOT_FIX : SLOT_DYN;
               id_q   <= (g == DBG_SLOT) ? DEBUG_ID : '0;
               cnt_q  <= '0;
            end else begin
               if (acc_v[g]) begin
                  mode_q <= cfg_fixed;
                  id_q   <= cfg_id;
               end else if (bind_w[g]) begin
                  id_q   <= bind_w_id;
               end else if (bind_r[g]) begin
                  id_q   <= bind_r_id;
               end
               cnt_q <= cnt_q + CNT_W'(inc_w[g]) + CNT_W'(inc_r[g])
                              - CNT_W'(dec_w[g]) - CNT_W'(dec_r[g]);
            end
         end

         assign fixed_o[g] = mode_q;
         assign bind_o[g]  = id_q;
         assign cnt_o[g]   = cnt_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           cfg_err <= 1'b0;
      else if (|rej_v)      cfg_err <= 1'b1;
      else if (|acc_v)      cfg_err <= 1'b0;
   end
endmodule

// File: rtl/idmap_remap.sv
module idmap_remap
   import idmap_pkg::*;
#(
   parameter int unsigned IN_ID_W    = 12,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WIN_W      = 30,
   parameter int unsigned WIN_TOP    = 2,
   parameter int unsigned USER_W     = 5,
   parameter logic [USER_W-1:0] USER_KEEP = 5'b11110,
   parameter logic [USER_W-1:0] USER_SET  = 5'b00001,
   parameter int unsigned FIRST_SLOT = 2,
   parameter int unsigned FIX_LAST   = 6,
   parameter int unsigned DBG_SLOT   = 2,
   parameter logic [IN_ID_W-1:0] DEBUG_ID = 12'h0A5,
   parameter int unsigned MAX_OUT    = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [2:0]           cfg_slot,
   input  logic                 cfg_fixed,
   input  logic [IN_ID_W-1:0]   cfg_id,
   output logic                 cfg_err,
   input  logic                 s_aw_valid,
   output logic                 s_aw_ready,
   input  logic [IN_ID_W-1:0]   s_aw_id,
   input  logic [ADDR_W-1:0]    s_aw_addr,
   input  logic [USER_W-1:0]    s_aw_user,
   output logic                 m_aw_valid,
   input  logic                 m_aw_ready,
   output logic [2:0]           m_aw_id,
   output logic [ADDR_W-1:0]    m_aw_addr,
   output logic [USER_W-1:0]    m_aw_user,
   input  logic                 s_ar_valid,
   output logic                 s_ar_ready,
   input  logic [IN_ID_W-1:0]   s_ar_id,
   input  logic [ADDR_W-1:0]    s_ar_addr,
   input  logic [USER_W-1:0]    s_ar_user,
   output logic                 m_ar_valid,
   input  logic                 m_ar_ready,
   output logic [2:0]           m_ar_id,
   output logic [ADDR_W-1:0]    m_ar_addr,
   output logic [USER_W-1:0]    m_ar_user,
   input  logic                 m_b_valid,
   output logic                 m_b_ready,
   input  logic [2:0]           m_b_id,
   output logic                 s_b_valid,
   input  logic                 s_b_ready,
   output logic [IN_ID_W-1:0]   s_b_id,
   input  logic                 m_r_valid,
   output logic                 m_r_ready,
   input  logic [2:0]           m_r_id,
   input  logic                 m_r_last,
   output logic                 s_r_valid,
   input  logic                 s_r_ready,
   output logic [IN_ID_W-1:0]   s_r_id,
   output logic                 s_r_last
);
   localparam int unsigned CNT_W = $clog2(MAX_OUT + 1);
   localparam int unsigned TOP_W = ADDR_W - WIN_W;
   localparam logic [TOP_W-1:0] WIN_TOP_V = TOP_W'(WIN_TOP);

   if (FIRST_SLOT < 1 || FIRST_SLOT > FIX_LAST) begin : g_bad_first
      $error("FIRST_SLOT must lie in 1..FIX_LAST");
   end
   if (FIX_LAST >= NSLOT) begin : g_bad_last
      $error("FIX_LAST must be below the slot count");
   end
   if (DBG_SLOT < FIRST_SLOT || DBG_SLOT > FIX_LAST) begin : g_bad_dbg
      $error("DBG_SLOT must be a fixable slot");
   end
   if (WIN_W >= ADDR_W || MAX_OUT < 2) begin : g_bad_win
      $error("window must be smaller than the address space, MAX_OUT at least 2");
   end

   logic [NSLOT-1:0]               slot_fixed;
   logic [NSLOT-1:0][IN_ID_W-1:0]  slot_bind;
   logic [NSLOT-1:0][CNT_W-1:0]    slot_cnt;

   logic aw_found, aw_alloc, aw_full, aw_go, aw_claim, aw_fire;
   logic ar_found, ar_alloc, ar_full, ar_go, ar_fire;
   oid_t aw_slot, ar_slot;
   logic [NSLOT-1:0] ar_block;
   logic b_fire, r_done;

   idmap_lookup #(.IN_ID_W(IN_ID_W), .FIRST(FIRST_SLOT), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_aw_look (
      .req_id(s_aw_id), .fixed(slot_fixed), .binding(slot_bind), .cnt(slot_cnt),
      .block('0), .found(aw_found), .alloc(aw_alloc), .full(aw_full), .slot(aw_slot));

   // write side wins a new slot; read side must skip the slot the write is taking
   assign aw_go    = aw_found && !aw_full;
   assign aw_claim = s_aw_valid && aw_go && aw_alloc;
   assign ar_block = aw_claim ? (NSLOT'(1) << aw_slot) : '0;

   idmap_lookup #(.IN_ID_W(IN_ID_W), .FIRST(FIRST_SLOT), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_ar_look (
      .req_id(s_ar_id), .fixed(slot_fixed), .binding(slot_bind), .cnt(slot_cnt),
      .block(ar_block), .found(ar_found), .alloc(ar_alloc), .full(ar_full), .slot(ar_slot));

   always_comb begin
      ar_go = ar_found && !ar_full;
      if (aw_claim && ar_alloc && s_ar_id == s_aw_id)
         ar_go = 1'b0;
      if (s_aw_valid && aw_go && aw_slot == ar_slot && slot_cnt[ar_slot] == CNT_W'(MAX_OUT - 1))
         ar_go = 1'b0;
   end

   assign m_aw_valid = s_aw_valid && aw_go;
   assign s_aw_ready = aw_go && m_aw_ready;
   assign m_aw_id    = aw_slot;
   assign m_aw_addr  = {WIN_TOP_V, s_aw_addr[WIN_W-1:0]};
   assign m_aw_user  = (s_aw_user & USER_KEEP) | USER_SET;
   assign aw_fire    = s_aw_valid && s_aw_ready;

   assign m_ar_valid = s_ar_valid && ar_go;
   assign s_ar_ready = ar_go && m_ar_ready;
   assign m_ar_id    = ar_slot;
   assign m_ar_addr  = {WIN_TOP_V, s_ar_addr[WIN_W-1:0]};
   assign m_ar_user  = (s_ar_user & USER_KEEP) | USER_SET;
   assign ar_fire    = s_ar_valid && s_ar_ready;

   wire unused_hi = ^{s_aw_addr[ADDR_W-1:WIN_W], s_ar_addr[ADDR_W-1:WIN_W]};

   assign s_b_valid = m_b_valid;
   assign m_b_ready = s_b_ready;
   assign s_b_id    = slot_bind[m_b_id];
   assign b_fire    = m_b_valid && s_b_ready;

   assign s_r_valid = m_r_valid;
   assign m_r_ready = s_r_ready;
   assign s_r_id    = slot_bind[m_r_id];
   assign s_r_last  = m_r_last;
   assign r_done    = m_r_valid && s_r_ready && m_r_last;

   idmap_slot_table #(
      .IN_ID_W(IN_ID_W), .FIRST(FIRST_SLOT), .FIX_LAST(FIX_LAST),
      .DBG_SLOT(DBG_SLOT), .DEBUG_ID(DEBUG_ID), .CNT_W(CNT_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_fixed(cfg_fixed), .cfg_id(cfg_id),
      .cfg_err(cfg_err),
      .inc_w(aw_fire ? (NSLOT'(1) << aw_slot) : '0),
      .inc_r(ar_fire ? (NSLOT'(1) << ar_slot) : '0),
      .dec_w(b_fire ? (NSLOT'(1) << m_b_id) : '0),
      .dec_r(r_done ? (NSLOT'(1) << m_r_id) : '0),
      .bind_w((aw_fire && aw_alloc) ? (NSLOT'(1) << aw_slot) : '0),
      .bind_w_id(s_aw_id),
      .bind_r((ar_fire && ar_alloc) ? (NSLOT'(1) << ar_slot) : '0),
      .bind_r_id(s_ar_id),
      .fixed_o(slot_fixed), .bind_o(slot_bind), .cnt_o(slot_cnt));
endmodule

// File: rtl/idmap_remap_chk.sv
module idmap_remap_chk
   import idmap_pkg::*;
#(
   parameter int unsigned IN_ID_W    = 12,
   parameter int unsigned FIRST_SLOT = 2,
   parameter int unsigned FIX_LAST   = 6,
   parameter int unsigned MAX_OUT    = 6,
   parameter int unsigned CNT_W      = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           m_aw_valid,
   input logic                           m_aw_ready,
   input logic [2:0]                     m_aw_id,
   input logic [IN_ID_W-1:0]             s_aw_id,
   input logic                           m_ar_valid,
   input logic [2:0]                     m_ar_id,
   input logic                           cfg_we,
   input logic [2:0]                     cfg_slot,
   input logic                           cfg_fixed,
   input logic                           cfg_err,
   input logic [NSLOT-1:0]               fixed_q,
   input logic [NSLOT-1:0][IN_ID_W-1:0]  bind_q,
   input logic [NSLOT-1:0][CNT_W-1:0]    cnt_q
);
   AST_NO_RSVD_AW: assert property (@(posedge clk) disable iff (!rst_n)
      m_aw_valid |-> m_aw_id >= OID_W'(FIRST_SLOT));  // R1
   AST_NO_RSVD_AR: assert property (@(posedge clk) disable iff (!rst_n)
      m_ar_valid |-> m_ar_id >= OID_W'(FIRST_SLOT));  // R1

   for (genvar g = FIX_LAST + 1; g < NSLOT; g++) begin : g_dyn_only
      AST_DYN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
         !fixed_q[g]);  // R2
   end

   AST_FIXED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (m_aw_valid && fixed_q[m_aw_id]) |-> bind_q[m_aw_id] == s_aw_id);  // R3

   AST_DYN_BIND: assert property (@(posedge clk) disable iff (!rst_n)
      (m_aw_valid && m_aw_ready && !fixed_q[m_aw_id]) |=> bind_q[$past(m_aw_id)] == $past(s_aw_id));  // R4

   AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (m_aw_valid && m_ar_valid && !fixed_q[m_aw_id] && !fixed_q[m_ar_id]
       && cnt_q[m_aw_id] == '0 && cnt_q[m_ar_id] == '0) |-> m_aw_id < m_ar_id);  // R11

   for (genvar g = 0; g < NSLOT; g++) begin : g_lim
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q[g] <= CNT_W'(MAX_OUT));  // R10
   end

   AST_CFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_slot >= OID_W'(FIRST_SLOT) && !(cfg_slot > OID_W'(FIX_LAST) && cfg_fixed)
       && cnt_q[cfg_slot] != '0) |=> cfg_err);  // R12
endmodule

bind idmap_remap idmap_remap_chk #(
   .IN_ID_W(IN_ID_W), .FIRST_SLOT(FIRST_SLOT), .FIX_LAST(FIX_LAST),
   .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_id(m_aw_id), .s_aw_id(s_aw_id),
   .m_ar_valid(m_ar_valid), .m_ar_id(m_ar_id),
   .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_fixed(cfg_fixed), .cfg_err(cfg_err),
   .fixed_q(slot_fixed), .bind_q(slot_bind), .cnt_q(slot_cnt));

// File: tb/idmap_remap_bench.sv
module idmap_remap_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic        cfg_we, cfg_fixed, cfg_err;
   logic [2:0]  cfg_slot;
   logic [11:0] cfg_id;
   logic        s_aw_valid, s_aw_ready, m_aw_valid, m_aw_ready;
   logic [11:0] s_aw_id;
   logic [31:0] s_aw_addr, m_aw_addr;
   logic [4:0]  s_aw_user, m_aw_user;
   logic [2:0]  m_aw_id;
   logic        s_ar_valid, s_ar_ready, m_ar_valid, m_ar_ready;
   logic [11:0] s_ar_id;
   logic [31:0] s_ar_addr, m_ar_addr;
   logic [4:0]  s_ar_user, m_ar_user;
   logic [2:0]  m_ar_id;
   logic        m_b_valid, m_b_ready, s_b_valid, s_b_ready;
   logic [2:0]  m_b_id;
   logic [11:0] s_b_id;
   logic        m_r_valid, m_r_ready, m_r_last, s_r_valid, s_r_ready, s_r_last;
   logic [2:0]  m_r_id;
   logic [11:0] s_r_id;

   idmap_remap u_idmap_remap (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_fixed(cfg_fixed), .cfg_id(cfg_id), .cfg_err(cfg_err),
      .s_aw_valid(s_aw_valid), .s_aw_ready(s_aw_ready), .s_aw_id(s_aw_id), .s_aw_addr(s_aw_addr),
      .s_aw_user(s_aw_user), .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_id(m_aw_id),
      .m_aw_addr(m_aw_addr), .m_aw_user(m_aw_user),
      .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready), .s_ar_id(s_ar_id), .s_ar_addr(s_ar_addr),
      .s_ar_user(s_ar_user), .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready), .m_ar_id(m_ar_id),
      .m_ar_addr(m_ar_addr), .m_ar_user(m_ar_user),
      .m_b_valid(m_b_valid), .m_b_ready(m_b_ready), .m_b_id(m_b_id),
      .s_b_valid(s_b_valid), .s_b_ready(s_b_ready), .s_b_id(s_b_id),
      .m_r_valid(m_r_valid), .m_r_ready(m_r_ready), .m_r_id(m_r_id), .m_r_last(m_r_last),
      .s_r_valid(s_r_valid), .s_r_ready(s_r_ready), .s_r_id(s_r_id), .s_r_last(s_r_last));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic        awv;
      logic [11:0] awid;
      logic        arv;
      logic [11:0] arid;
      logic        eaw;
      logic [2:0]  eawo;
      logic        ear;
      logic [2:0]  earo;
   } row_t;

   localparam int NROW = 6;
   localparam row_t TBL [NROW] = '{
      '{1'b1, 12'h0A5, 1'b0, 12'h000, 1'b1, 3'd2, 1'b0, 3'd0},
      '{1'b1, 12'h011, 1'b1, 12'h022, 1'b1, 3'd3, 1'b1, 3'd4},
      '{1'b1, 12'h033, 1'b1, 12'h011, 1'b1, 3'd5, 1'b1, 3'd3},
      '{1'b1, 12'h044, 1'b1, 12'h055, 1'b1, 3'd6, 1'b1, 3'd7},
      '{1'b1, 12'h066, 1'b1, 12'h0A5, 1'b0, 3'd0, 1'b1, 3'd2},
      '{1'b0, 12'h000, 1'b1, 12'h077, 1'b0, 3'd0, 1'b0, 3'd0}
   };

   function automatic string row_tag(input int k);
      case (k)
         0: return "R3";
         1: return "R11";
         2: return "R5";
         3: return "R4";
         4: return "R10 R1";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle;
      cfg_we = 0; cfg_slot = 0; cfg_fixed = 0; cfg_id = 0;
      s_aw_valid = 0; s_aw_id = 0; s_aw_addr = 0; s_aw_user = 0;
      s_ar_valid = 0; s_ar_id = 0; s_ar_addr = 0; s_ar_user = 0;
      m_b_valid = 0; m_b_id = 0; m_r_valid = 0; m_r_id = 0; m_r_last = 0;
      m_aw_ready = 1; m_ar_ready = 1; s_b_ready = 1; s_r_ready = 1;
   endtask

   task automatic do_reset;
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R6 aw valid after reset", 32'(m_aw_valid), 0);
      chk("R6 ar valid after reset", 32'(m_ar_valid), 0);
      chk("R6 cfg_err after reset", 32'(cfg_err), 0);
   endtask

   // one write request held for one cycle; checks go and ID before the edge
   task automatic aw_req(input string tag, input logic [11:0] id, input logic eg, input logic [2:0] eo);
      s_aw_valid = 1; s_aw_id = id;
      #2;
      chk(tag, 32'(m_aw_valid), 32'(eg));
      if (eg) chk(tag, 32'(m_aw_id), 32'(eo));
      @(negedge clk);
      s_aw_valid = 0;
   endtask

   task automatic cfg_wr(input logic [2:0] slot, input logic fx, input logic [11:0] id);
      cfg_we = 1; cfg_slot = slot; cfg_fixed = fx; cfg_id = id;
      @(negedge clk);
      cfg_we = 0;
      #2;
   endtask

   initial begin
      @(negedge clk);
      // ---------- phase 1 ----------
      do_reset();
      for (int k = 0; k < NROW; k++) begin
         s_aw_valid = TBL[k].awv; s_aw_id = TBL[k].awid;
         s_ar_valid = TBL[k].arv; s_ar_id = TBL[k].arid;
         #2;
         chk(row_tag(k), 32'(m_aw_valid), 32'(TBL[k].eaw));
         chk(row_tag(k), 32'(s_aw_ready), 32'(TBL[k].eaw));
         if (TBL[k].eaw) chk(row_tag(k), 32'(m_aw_id), 32'(TBL[k].eawo));
         chk(row_tag(k), 32'(m_ar_valid), 32'(TBL[k].ear));
         if (TBL[k].ear) chk(row_tag(k), 32'(m_ar_id), 32'(TBL[k].earo));
         @(negedge clk);
         s_aw_valid = 0; s_ar_valid = 0;
      end

      // R13: write response on slot 3 goes back with ID 0x011
      m_b_valid = 1; m_b_id = 3;
      #2;
      chk("R13 b id", 32'(s_b_id), 32'h011);
      chk("R13 b valid", 32'(s_b_valid), 1);
      chk("R13 b ready", 32'(m_b_ready), 1);
      @(negedge clk); m_b_valid = 0;
      m_r_valid = 1; m_r_id = 3; m_r_last = 1;
      #2;
      chk("R13 r id", 32'(s_r_id), 32'h011);
      @(negedge clk); m_r_valid = 0; m_r_last = 0;

      // R9: slot 3 is idle again and rebinds to a new ID
      aw_req("R9 reuse freed slot", 12'h066, 1, 3);

      // R9: beat without last keeps slot 4 busy
      m_r_valid = 1; m_r_id = 4; m_r_last = 0;
      @(negedge clk); m_r_valid = 0;
      aw_req("R9 no release without last", 12'h088, 0, 0);
      m_r_valid = 1; m_r_id = 4; m_r_last = 1;
      @(negedge clk); m_r_valid = 0; m_r_last = 0;
      aw_req("R9 release on last", 12'h088, 1, 4);

      // R12: slot 5 is busy, write is rejected and binding kept
      cfg_wr(3'd5, 1'b1, 12'h0BB);
      chk("R12 err on busy slot", 32'(cfg_err), 1);
      s_aw_valid = 1; s_aw_id = 12'h033; s_aw_addr = 32'h1234_5678; s_aw_user = 5'b10110;
      #2;
      chk("R12 binding unchanged", 32'(m_aw_id), 5);
      chk("R8 addr window", m_aw_addr, {2'b10, s_aw_addr[29:0]});
      chk("R7 user remap", 32'(m_aw_user), 32'((5'b10110 & 5'b11110) | 5'b00001));
      @(negedge clk); s_aw_valid = 0;
      s_ar_valid = 1; s_ar_id = 12'h0A5; s_ar_addr = 32'hFFFF_0001; s_ar_user = 5'b00000;
      #2;
      chk("R8 read addr window", m_ar_addr, 32'hBFFF_0001);
      chk("R7 read user remap", 32'(m_ar_user), 32'h01);
      @(negedge clk); s_ar_valid = 0;

      // ---------- phase 2 ----------
      do_reset();
      aw_req("R6 slot2 fixed at reset", 12'h0CC, 1, 3);
      cfg_wr(3'd7, 1'b1, 12'h0EE);
      chk("R2 fixed write to slot7 ignored", 32'(cfg_err), 0);
      cfg_wr(3'd1, 1'b1, 12'h0EE);
      chk("R2 write to reserved slot ignored", 32'(cfg_err), 0);
      cfg_wr(3'd4, 1'b1, 12'h0DD);
      chk("R12 idle slot accepted", 32'(cfg_err), 0);
      aw_req("R2 slot7 stays dynamic", 12'h0EE, 1, 5);
      aw_req("R3 new fixed binding", 12'h0DD, 1, 4);
      for (int k = 0; k < 6; k++) aw_req("R10 under limit", 12'h0A5, 1, 2);
      aw_req("R10 limit stall", 12'h0A5, 0, 0);
      s_ar_valid = 1; s_ar_id = 12'h0A5;
      #2;
      chk("R10 read stall at limit", 32'(s_ar_ready), 0);
      @(negedge clk); s_ar_valid = 0;

      cfg_wr(3'd3, 1'b1, 12'h0FF);
      chk("R12 reject busy", 32'(cfg_err), 1);
      aw_req("R12 rejected binding kept", 12'h0CC, 1, 3);
      cfg_wr(3'd6, 1'b0, 12'h000);
      chk("R12 accepted clears err", 32'(cfg_err), 0);

      m_b_valid = 1; m_b_id = 2;
      #2;
      chk("R13 fixed slot response", 32'(s_b_id), 32'h0A5);
      @(negedge clk); m_b_valid = 0;
      aw_req("R9 room after response", 12'h0A5, 1, 2);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule